// File: doc/BRIEF.md
# Double-Data-Rate Transmit Encoder for a Reduced Gigabit Media Interface

This block takes a byte-wide transmit word (eight data bits, a transmit enable and a transmit error flag) once per transmit clock cycle. It turns that word into a four-bit double-data-rate stream with one control line. The output is given as two nibbles, one for the rising half of the clock and one for the falling half, plus a control bit for each half. A pad-level DDR cell can then drive the pins from these registered values. The control line carries the enable in the rising half and enable XOR error in the falling half. As a result it holds steady through frames and idle periods, and it only toggles when an error or a carrier extension is signalled.

A mode input switches the block to ten-bit operation. A 10-bit code group is then split over the same four data lines and the control line. Every input is captured once, and both halves of each output cycle are built from that single captured word. The outputs are registered one more time, so each output follows the input word that was presented two clock edges earlier. The EN=0, ER=1 combinations that are not carrier-extend codes are reserved. They raise a flag and force the lines to idle.

Top module: `gmii_ddr_tx_enc`

## Requirements
- R1: In byte mode, the rising-half data nibble equals bits 3:0 of the data input and the falling-half nibble equals bits 7:4, for every non-reserved word.
- R2: In byte mode, the rising-half control bit equals the transmit enable of the word.
- R3: In byte mode, the falling-half control bit equals transmit enable XOR transmit error of the word.
- R4: Frame data (EN=1, ER=0) drives control high in both halves. An idle word (EN=0, ER=0) drives control low in both halves.
- R5: An in-frame error (EN=1, ER=1) drives control high in the rising half and low in the falling half. The data passes through unchanged.
- R6: With EN=0 and ER=1, data 0x0F (carrier extend) and 0x1F (extend with error) give control low then high, pass the data through and leave the reserved flag low.
- R7: Every other EN=0, ER=1 data value, including 0xFF, raises the reserved flag and drives both control bits and both nibbles to zero.
- R8: In ten-bit mode, code bits 3:0 go to the rising nibble, bits 8:5 to the falling nibble, bit 4 to the rising control and bit 9 to the falling control. The reserved flag stays low.
- R9: Each output cycle reflects the input word sampled two rising edges earlier, and a word is accepted on every cycle.
- R10: While reset is asserted, all outputs are zero.
- R11: The mode input changes only while the captured word and the one before it have enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Transmit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tbi_mode_i | input | 1 | 1 selects ten-bit code mode, 0 selects byte mode |
| txd_i | input | 8 | Byte-mode transmit data |
| tx_en_i | input | 1 | Byte-mode transmit enable |
| tx_er_i | input | 1 | Byte-mode transmit error |
| code_i | input | 10 | Ten-bit code group |
| rise_d_o | output | 4 | Data nibble for the rising clock half |
| fall_d_o | output | 4 | Data nibble for the falling clock half |
| rise_ctl_o | output | 1 | Control bit for the rising clock half |
| fall_ctl_o | output | 1 | Control bit for the falling clock half |
| rsvd_o | output | 1 | Reserved control/data code was requested |

## Verification
Checked on every cycle by the assertions: the control-bit relations to the captured enable and error, the forced idle lines while the reserved flag is high, the flag staying low in ten-bit mode, and the mode switching only at idle. Only the bench scenarios show the exact nibble split in both modes, the two-cycle latency of a back-to-back stream, the carrier-extend codes passing through and the reset state. The bench rebuilds each byte-mode word from the edge outputs and compares it with what it drove.

// File: rtl/gddr_pkg.sv
package gddr_pkg;
  localparam int NIB_W = 4;
  localparam logic [7:0] EXT_CODE     = 8'h0F;
  localparam logic [7:0] EXT_ERR_CODE = 8'h1F;

  typedef struct packed {
    logic [NIB_W-1:0] rise_d;
    logic [NIB_W-1:0] fall_d;
    logic             rise_ctl;
    logic             fall_ctl;
  } ddr_word_t;
endpackage

// File: rtl/txc_capture.sv
module txc_capture #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/byte_word_enc.sv
module byte_word_enc
  import gddr_pkg::*;
#(
  parameter int DATA_W = 2*NIB_W
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              en_i,
  input  logic              er_i,
  output ddr_word_t         word_o,
  output logic              rsvd_o
);
  localparam int HALF = DATA_W/2;

  logic is_ext;
  assign is_ext = (data_i == EXT_CODE) || (data_i == EXT_ERR_CODE);

  always_comb begin
    word_o = '0;
    rsvd_o = 1'b0;
    unique case ({en_i, er_i})
      2'b00: begin
        word_o.rise_d = data_i[HALF-1:0];
        word_o.fall_d = data_i[DATA_W-1:HALF];
      end
      2'b10: begin
        word_o = '{data_i[HALF-1:0], data_i[DATA_W-1:HALF], 1'b1, 1'b1};
      end
      2'b11: begin
        word_o = '{data_i[HALF-1:0], data_i[DATA_W-1:HALF], 1'b1, 1'b0};
      end
      default: begin
        if (is_ext) word_o = '{data_i[HALF-1:0], data_i[DATA_W-1:HALF], 1'b0, 1'b1};
        else        rsvd_o = 1'b1;  // reserved: lines stay idle
      end
    endcase
  end
endmodule

// File: rtl/code_word_map.sv
module code_word_map
  import gddr_pkg::*;
#(
  parameter int CODE_W = 2*(NIB_W+1)
) (
  input  logic [CODE_W-1:0] code_i,
  output ddr_word_t         word_o
);
  localparam int HALF = CODE_W/2;

  // each half: low bits on data lines, top bit on control
  assign word_o.rise_d   = code_i[HALF-2:0];
  assign word_o.rise_ctl = code_i[HALF-1];
  assign word_o.fall_d   = code_i[CODE_W-2:HALF];
  assign word_o.fall_ctl = code_i[CODE_W-1];
endmodule

// File: rtl/gmii_ddr_tx_enc.sv
module gmii_ddr_tx_enc
  import gddr_pkg::*;
#(
  parameter int DATA_W = 2*NIB_W,
  parameter int CODE_W = 2*(NIB_W+1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tbi_mode_i,
  input  logic [DATA_W-1:0] txd_i,
  input  logic              tx_en_i,
  input  logic              tx_er_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [NIB_W-1:0]  rise_d_o,
  output logic [NIB_W-1:0]  fall_d_o,
  output logic              rise_ctl_o,
  output logic              fall_ctl_o,
  output logic              rsvd_o
);
  localparam int CAP_W = 3 + DATA_W + CODE_W;

  logic [CAP_W-1:0]  cap_q;
  logic              mode_q, en_q, er_q;
  logic [DATA_W-1:0] data_q;
  logic [CODE_W-1:0] code_q;

  txc_capture #(.W(CAP_W)) u_cap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({tbi_mode_i, tx_en_i, tx_er_i, txd_i, code_i}),
    .q_o   (cap_q)
  );
  assign {mode_q, en_q, er_q, data_q, code_q} = cap_q;

  ddr_word_t byte_w, code_w, sel_w, out_q;
  logic      byte_rsvd, rsvd_q;

  byte_word_enc #(.DATA_W(DATA_W)) u_byte (
    .data_i(data_q),
    .en_i  (en_q),
    .er_i  (er_q),
    .word_o(byte_w),
    .rsvd_o(byte_rsvd)
  );

  code_word_map #(.CODE_W(CODE_W)) u_code (
    .code_i(code_q),
    .word_o(code_w)
  );

  assign sel_w = mode_q ? code_w : byte_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '0;
      rsvd_q <= 1'b0;
    end else begin
      out_q  <= sel_w;
      rsvd_q <= byte_rsvd & ~mode_q;
    end
  end

  assign rise_d_o   = out_q.rise_d;
  assign fall_d_o   = out_q.fall_d;
  assign rise_ctl_o = out_q.rise_ctl;
  assign fall_ctl_o = out_q.fall_ctl;
  assign rsvd_o     = rsvd_q;

  assert_ctl_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(mode_q) && !rsvd_o) |-> (rise_ctl_o == $past(en_q)));

  assert_ctl_fall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(mode_q) && !rsvd_o) |-> (fall_ctl_o == ($past(en_q) ^ $past(er_q))));

  assert_rsvd_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsvd_o |-> (!rise_ctl_o && !fall_ctl_o && rise_d_o == '0 && fall_d_o == '0));

  assert_rsvd_only_byte_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(mode_q) |-> !rsvd_o);

  assert_mode_at_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != $past(mode_q)) |-> (!en_q && !$past(en_q)));
endmodule

// File: tb/sim_gmii_ddr_tx_enc.sv
module sim_gmii_ddr_tx_enc;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode = 1'b0;
  logic [7:0] txd = '0;
  logic       en = 1'b0, er = 1'b0;
  logic [9:0] code = '0;
  logic [3:0] rd, fd;
  logic       rc, fc, rsvd;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gmii_ddr_tx_enc u0 (
    .clk_i(clk), .rst_ni(rst_n), .tbi_mode_i(mode), .txd_i(txd),
    .tx_en_i(en), .tx_er_i(er), .code_i(code),
    .rise_d_o(rd), .fall_d_o(fd), .rise_ctl_o(rc), .fall_ctl_o(fc), .rsvd_o(rsvd)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one word, wait for it to emerge two edges later, sample mid-cycle
  task automatic put_byte(input logic [7:0] d, input logic e, input logic r);
    @(negedge clk);
    txd = d; en = e; er = r;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_byte(input string req, input logic [7:0] d, input logic e, input logic r);
    put_byte(d, e, r);
    chk({req, " data rebuilt"}, {24'h0, fd, rd}, {24'h0, d});
    chk({req, " rise ctl (R2)"}, {31'h0, rc}, {31'h0, e});
    chk({req, " fall ctl (R3)"}, {31'h0, fc}, {31'h0, e ^ r});
    chk({req, " rsvd low"}, {31'h0, rsvd}, 32'h0);
  endtask

  task automatic t_reset;
    chk("R10 reset outputs", {21'h0, rd, fd, rc, fc, rsvd}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_frame_idle;
    chk_byte("R4 idle", 8'hA5, 1'b0, 1'b0);
    chk_byte("R4 frame R1", 8'h3C, 1'b1, 1'b0);
    chk_byte("R1 frame", 8'hE7, 1'b1, 1'b0);
  endtask

  task automatic t_in_frame_err;
    chk_byte("R5 error", 8'h5A, 1'b1, 1'b1);
  endtask

  task automatic t_extend;
    chk_byte("R6 extend", 8'h0F, 1'b0, 1'b1);
    chk_byte("R6 extend err", 8'h1F, 1'b0, 1'b1);
  endtask

  task automatic t_reserved;
    logic [7:0] vals [4] = '{8'hFF, 8'h00, 8'h0E, 8'h2F};
    foreach (vals[i]) begin
      put_byte(vals[i], 1'b0, 1'b1);
      chk("R7 rsvd flag", {31'h0, rsvd}, 32'h1);
      chk("R7 rsvd lines idle", {22'h0, rd, fd, rc, fc}, 32'h0);
    end
    chk_byte("R7 flag clears", 8'h11, 1'b1, 1'b0);
  endtask

  task automatic t_stream;
    logic [7:0] d [8];
    logic       e [8];
    logic       r [8];
    for (int k = 0; k < 8; k++) begin
      d[k] = 8'(8'h21 * k + 8'h13);
      e[k] = (k != 0) && (k != 7);
      r[k] = (k == 4);
    end
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (k >= 2) begin
        chk("R9 stream data", {24'h0, fd, rd}, {24'h0, d[k-2]});
        chk("R9 stream ctl", {30'h0, rc, fc}, {30'h0, e[k-2], e[k-2] ^ r[k-2]});
      end
      if (k < 8) begin txd = d[k]; en = e[k]; er = r[k]; end
      else begin txd = '0; en = 1'b0; er = 1'b0; end
    end
  endtask

  task automatic t_tbi;
    logic [9:0] codes [3] = '{10'h3A5, 10'h17C, 10'h2D1};
    @(negedge clk); txd = '0; en = 1'b0; er = 1'b0;
    repeat (2) @(negedge clk);
    mode = 1'b1;  // R11: switched while idle
    foreach (codes[i]) begin
      @(negedge clk); code = codes[i];
      txd = 8'hFF; er = 1'b1;  // byte inputs ignored in ten-bit mode
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R8 rise nibble", {28'h0, rd}, {28'h0, codes[i][3:0]});
      chk("R8 fall nibble", {28'h0, fd}, {28'h0, codes[i][8:5]});
      chk("R8 ctl bits", {30'h0, rc, fc}, {30'h0, codes[i][4], codes[i][9]});
      chk("R8 rsvd low", {31'h0, rsvd}, 32'h0);
    end
    @(negedge clk); txd = '0; er = 1'b0; code = '0;
    repeat (2) @(negedge clk);
    mode = 1'b0;
    chk_byte("R11 back to byte mode", 8'h96, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    t_frame_idle;
    t_in_frame_err;
    t_extend;
    t_reserved;
    t_stream;
    t_tbi;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule